// File: doc/BRIEF.md
# Banked Internal Data Memory with Bit Access

This block holds the 256-byte on-chip data memory of an 8-bit controller core and resolves every operand-addressing form that the core's decoder can issue against it. The decoder presents one access per cycle as an operation code, an 8-bit operand field and, for writes, a data byte or data bit. Working registers are reached relative to a bank chosen by two status bits. Indirect accesses go through a pointer register of the active bank. Single bits are reached in a 128-bit window of RAM bytes and in the bit-capable columns of the special-function space.

Direct accesses at 0x80 and above leave the RAM and appear on a special-function port, where a neighbouring block answers with a data byte and a hit flag. Indirect accesses to the same addresses stay in RAM, which gives the upper 128 bytes that only pointers can reach. Bit writes are done as a read-modify-write of the containing byte within the request cycle, in RAM or through the special-function port. Read results and the error flag are registered and appear one cycle after the request.

Top module: `banked_iram`

## Requirements
- R1: After a synchronous reset, rvalid, err, rdata and rbit are all zero. RAM contents are not defined by reset.
- R2: Operation codes 5 (register read) and 6 (register write) reach register n = req_addr[2:0] at byte address {bank_sel, n}, which is 8*bank_sel + n, so the same n in different banks reaches different bytes.
- R3: Operation codes 3 (indirect read) and 4 (indirect write) use as the address the current value of byte {bank_sel, 2'b00, req_addr[0]}, which is R0 or R1 of the active bank. They reach all 256 RAM bytes and never assert sfr_rd or sfr_wr.
- R4: Operation codes 1 (direct read) and 2 (direct write) with req_addr below 0x80 access that RAM byte. From 0x80 upward they assert sfr_rd or sfr_wr with sfr_addr = req_addr and leave RAM untouched.
- R5: Operation codes 7 to 10 with a bit address b below 0x80 act on bit b[2:0] of RAM byte 0x20 + b[6:3]. For example, 0x13 is bit 3 of byte 0x22 and 0x7F is bit 7 of byte 0x2F.
- R6: Code 8 sets the bit, code 9 clears it and code 10 writes req_wbit. The other seven bits of the byte keep their values, and the change is visible to a byte read in the next access.
- R7: A bit address b of 0x80 or more acts on the special-function byte b with its low three bits cleared, bit b[2:0]. It asserts sfr_rd, and for codes 8 to 10 it also asserts sfr_wr in the same cycle, with sfr_wdata equal to sfr_rdata apart from the addressed bit.
- R8: sfr_bitable is high exactly when the special-function port is addressed and sfr_addr[2:0] is zero, that is, when the low nibble is 0x0 or 0x8.
- R9: When the special-function port is addressed while sfr_hit is low, err is high in the following cycle. If that access is a read, rdata and rbit return zero.
- R10: A read (codes 1, 3, 5, 7) gives rvalid high in the next cycle with rdata and, for code 7, rbit. For code 7, rdata carries the whole containing byte. Writes and code 0 give rvalid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 4 | Operation code (0 none, 1 to 10 as listed in the requirements) |
| req_addr | input | AW | Direct address, register number, pointer select or bit address |
| req_wdata | input | DW | Byte written by codes 2, 4, 6 |
| req_wbit | input | 1 | Bit value written by code 10 |
| bank_sel | input | 2 | Active register bank (status bits RS1:RS0) |
| rvalid | output | 1 | Read result valid |
| rdata | output | DW | Read byte |
| rbit | output | 1 | Read bit for code 7 |
| err | output | 1 | Previous access hit an unimplemented special-function address |
| sfr_rd | output | 1 | Special-function read strobe |
| sfr_wr | output | 1 | Special-function write strobe |
| sfr_addr | output | AW | Special-function byte address |
| sfr_wdata | output | DW | Special-function write byte |
| sfr_rdata | input | DW | Special-function read byte, answered in the same cycle |
| sfr_hit | input | 1 | Addressed special-function register exists |
| sfr_bitable | output | 1 | Addressed special-function register is bit-addressable |

## Verification
The assertions take for granted that the special-function neighbour answers sfr_rdata and sfr_hit combinationally in the same cycle as the strobe, and that every RAM byte used as a pointer or read back has been written since power-up. The stimulus keeps to both conditions. The bench model answers the port from its own array, with a hit for every address whose low nibble is not 0xF. Before any random traffic, an initial pass writes all 256 RAM bytes, the upper half through R0, so that random indirect, register and bit accesses never read an unwritten byte.

// File: rtl/iram_pkg.sv
package iram_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_DIR_RD  = 4'd1,
    OP_DIR_WR  = 4'd2,
    OP_IND_RD  = 4'd3,
    OP_IND_WR  = 4'd4,
    OP_REG_RD  = 4'd5,
    OP_REG_WR  = 4'd6,
    OP_BIT_RD  = 4'd7,
    OP_BIT_SET = 4'd8,
    OP_BIT_CLR = 4'd9,
    OP_BIT_WR  = 4'd10
  } op_e;

endpackage

// File: rtl/iram_store.sv
module iram_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/iram_ptr_shadow.sv
module iram_ptr_shadow #(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int BANKS = 4,
  parameter int REGS  = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(BANKS)-1:0] bank,
  output logic [DW-1:0]            ptr0,
  output logic [DW-1:0]            ptr1
);

  localparam int BW = $clog2(BANKS);
  localparam int RW = $clog2(REGS);

  logic [DW-1:0] p0 [BANKS];
  logic [DW-1:0] p1 [BANKS];
  logic          in_regs;

  assign in_regs = (waddr[AW-1:BW+RW] == '0) && (waddr[RW-1:1] == '0);

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic [DW-1:0] r0_q, r1_q;
    logic          sel;
    assign sel = we && in_regs && (waddr[RW +: BW] == BW'(g));
    always_ff @(posedge clk) begin
      if (sel && !waddr[0]) r0_q <= wdata;
      if (sel &&  waddr[0]) r1_q <= wdata;
    end
    assign p0[g] = r0_q;
    assign p1[g] = r1_q;
  end

  assign ptr0 = p0[bank];
  assign ptr1 = p1[bank];

endmodule

// File: rtl/iram_route.sv
module iram_route
  import iram_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int BANKS    = 4,
  parameter int REGS     = 8,
  parameter int BIT_BASE = 'h20
) (
  input  op_e                      op,
  input  logic [AW-1:0]            addr,
  input  logic [$clog2(BANKS)-1:0] bank,
  input  logic [DW-1:0]            ptr0,
  input  logic [DW-1:0]            ptr1,
  output logic [AW-1:0]            ram_addr,
  output logic [AW-1:0]            sfr_addr,
  output logic [$clog2(DW)-1:0]    bit_idx,
  output logic                     to_sfr,
  output logic                     rd,
  output logic                     wr,
  output logic                     bit_op,
  output logic                     ind_op
);

  localparam int BIW = $clog2(DW);
  localparam int RW  = $clog2(REGS);
  localparam logic [AW-1:0] WIN_LO = AW'(BIT_BASE);

  always_comb begin
    ram_addr = addr;
    sfr_addr = addr;
    bit_idx  = addr[BIW-1:0];
    to_sfr   = 1'b0;
    rd       = 1'b0;
    wr       = 1'b0;
    bit_op   = 1'b0;
    ind_op   = 1'b0;
    unique case (op)
      OP_DIR_RD, OP_DIR_WR: begin
        to_sfr = addr[AW-1];
        rd     = (op == OP_DIR_RD);
        wr     = (op == OP_DIR_WR);
      end
      OP_IND_RD, OP_IND_WR: begin
        ind_op   = 1'b1;
        ram_addr = addr[0] ? AW'(ptr1) : AW'(ptr0);
        rd       = (op == OP_IND_RD);
        wr       = (op == OP_IND_WR);
      end
      OP_REG_RD, OP_REG_WR: begin
        ram_addr = AW'({bank, addr[RW-1:0]});
        rd       = (op == OP_REG_RD);
        wr       = (op == OP_REG_WR);
      end
      OP_BIT_RD, OP_BIT_SET, OP_BIT_CLR, OP_BIT_WR: begin
        bit_op   = 1'b1;
        to_sfr   = addr[AW-1];
        ram_addr = WIN_LO + AW'(addr[AW-2:BIW]);
        sfr_addr = {addr[AW-1:BIW], BIW'(0)};
        rd       = (op == OP_BIT_RD);
        wr       = (op != OP_BIT_RD);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/banked_iram.sv
module banked_iram
  import iram_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int BANKS    = 4,
  parameter int REGS     = 8,
  parameter int BIT_BASE = 'h20,
  localparam int BW      = $clog2(BANKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_wbit,
  input  logic [BW-1:0] bank_sel,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  output logic          rbit,
  output logic          err,
  output logic          sfr_rd,
  output logic          sfr_wr,
  output logic [AW-1:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata,
  input  logic          sfr_hit,
  output logic          sfr_bitable
);

  localparam int BIW       = $clog2(DW);
  localparam int WIN_BYTES = (2 ** (AW - 1)) / DW;
  localparam logic [AW-1:0] WIN_LO = AW'(BIT_BASE);
  localparam logic [AW-1:0] WIN_HI = AW'(BIT_BASE + WIN_BYTES - 1);

  op_e            op;
  logic [AW-1:0]  ram_addr;
  logic [BIW-1:0] bit_idx;
  logic           to_sfr, rd, wr, bit_op, ind_op;
  logic [DW-1:0]  ptr0, ptr1;
  logic [DW-1:0]  ram_rdata, ram_wdata, cur_byte, new_byte;
  logic           ram_we, cur_bit, miss;
  logic           rvalid_q, rbit_q, err_q;
  logic [DW-1:0]  rdata_q;

  assign op = op_e'(req_op);

  iram_route #(
    .AW(AW), .DW(DW), .BANKS(BANKS), .REGS(REGS), .BIT_BASE(BIT_BASE)
  ) u_route (
    .op(op), .addr(req_addr), .bank(bank_sel), .ptr0(ptr0), .ptr1(ptr1),
    .ram_addr(ram_addr), .sfr_addr(sfr_addr), .bit_idx(bit_idx),
    .to_sfr(to_sfr), .rd(rd), .wr(wr), .bit_op(bit_op), .ind_op(ind_op)
  );

  iram_ptr_shadow #(
    .AW(AW), .DW(DW), .BANKS(BANKS), .REGS(REGS)
  ) u_shadow (
    .clk(clk), .we(ram_we), .waddr(ram_addr), .wdata(ram_wdata),
    .bank(bank_sel), .ptr0(ptr0), .ptr1(ptr1)
  );

  iram_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
  );

  // Byte currently held at the target, from RAM or from the neighbour.
  assign cur_byte = to_sfr ? sfr_rdata : ram_rdata;
  assign cur_bit  = cur_byte[bit_idx];
  assign miss     = to_sfr && !sfr_hit;

  always_comb begin
    new_byte = req_wdata;
    if (bit_op) begin
      new_byte = cur_byte;
      unique case (op)
        OP_BIT_SET: new_byte[bit_idx] = 1'b1;
        OP_BIT_CLR: new_byte[bit_idx] = 1'b0;
        OP_BIT_WR:  new_byte[bit_idx] = req_wbit;
        default: ;
      endcase
    end
  end

  assign ram_we      = wr && !to_sfr;
  assign ram_wdata   = new_byte;
  assign sfr_rd      = to_sfr && (rd || bit_op);
  assign sfr_wr      = to_sfr && wr;
  assign sfr_wdata   = new_byte;
  assign sfr_bitable = to_sfr && (sfr_addr[BIW-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      rbit_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= rd;
      err_q    <= miss;
      if (rd) begin
        rdata_q <= miss ? '0 : cur_byte;
        rbit_q  <= miss ? 1'b0 : cur_bit;
      end
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
  assign rbit   = rbit_q;
  assign err    = err_q;

  // R9
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q && rvalid_q) |-> (rdata_q == '0 && !rbit_q));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> ($past(sfr_rd || sfr_wr) && !$past(sfr_hit)));

  // R7
  sfr_rmw_chk: assert property (@(posedge clk) disable iff (rst)
    (sfr_wr && bit_op) |-> ($countones(sfr_wdata ^ sfr_rdata) <= 1));

  // R6
  ram_rmw_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we && bit_op) |-> ($countones(ram_wdata ^ ram_rdata) <= 1));

  // R3
  ind_no_sfr_chk: assert property (@(posedge clk) disable iff (rst)
    ind_op |-> (!sfr_rd && !sfr_wr));

  // R10
  rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid_q |-> $past(op == OP_DIR_RD || op == OP_IND_RD ||
                       op == OP_REG_RD || op == OP_BIT_RD));

  // R5
  bit_win_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_op && !to_sfr) |-> (ram_addr >= WIN_LO && ram_addr <= WIN_HI));

endmodule

// File: tb/test_banked_iram.sv
module test_banked_iram;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] req_op;
  logic [7:0] req_addr, req_wdata;
  logic       req_wbit;
  logic [1:0] bank;
  logic       rvalid, rbit, err, sfr_rd, sfr_wr, sfr_hit, sfr_bitable;
  logic [7:0] rdata, sfr_addr, sfr_wdata, sfr_rdata;

  logic [7:0] ram [256];
  logic [7:0] sfr_mem [128];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  banked_iram i_banked_iram (
    .clk(clk), .rst(rst), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wbit(req_wbit), .bank_sel(bank),
    .rvalid(rvalid), .rdata(rdata), .rbit(rbit), .err(err),
    .sfr_rd(sfr_rd), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit),
    .sfr_bitable(sfr_bitable)
  );

  // Special-function neighbour: every address with low nibble 0xF is absent.
  assign sfr_hit   = (sfr_addr[3:0] != 4'hF);
  assign sfr_rdata = sfr_hit ? sfr_mem[sfr_addr[6:0]] : 8'hA5;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bit_byte(input logic [7:0] b);
    return b[7] ? {b[7:3], 3'b000} : 8'h20 + {4'h0, b[6:3]};
  endfunction

  task automatic do_op(input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] wd, input logic wb);
    logic is_dir, is_ind, is_reg, is_bit, rdop, wrop, sfr_t, hit;
    logic [7:0] tadr, oldv, newv, expd;
    logic [2:0] bi;
    string tag;
    is_dir = (op == 1 || op == 2);
    is_ind = (op == 3 || op == 4);
    is_reg = (op == 5 || op == 6);
    is_bit = (op >= 7 && op <= 10);
    rdop   = (op == 1 || op == 3 || op == 5 || op == 7);
    wrop   = (op == 2 || op == 4 || op == 6 || (op >= 8 && op <= 10));
    sfr_t  = (is_dir || is_bit) && a[7];
    bi     = a[2:0];
    if (is_dir)      tadr = a;
    else if (is_ind) tadr = ram[{bank, 2'b00, a[0]}];
    else if (is_reg) tadr = {3'b000, bank, a[2:0]};
    else if (is_bit) tadr = bit_byte(a);
    else             tadr = 8'h00;
    hit  = !sfr_t || (tadr[3:0] != 4'hF);
    oldv = sfr_t ? (hit ? sfr_mem[tadr[6:0]] : 8'hA5) : ram[tadr];
    newv = oldv;
    case (op)
      4'd8:    newv[bi] = 1'b1;
      4'd9:    newv[bi] = 1'b0;
      4'd10:   newv[bi] = wb;
      default: newv = wd;
    endcase
    if (is_reg) tag = "R2";
    else if (is_ind) tag = "R3";
    else if (is_dir) tag = "R4";
    else if (is_bit && sfr_t) tag = "R7";
    else if (is_bit && rdop) tag = "R5";
    else if (is_bit) tag = "R6";
    else tag = "R10";
    req_op = op; req_addr = a; req_wdata = wd; req_wbit = wb;
    #1;
    chk(sfr_rd == (sfr_t && (rdop || is_bit)), tag, {7'd0, sfr_rd}, {7'd0, sfr_t && (rdop || is_bit)});
    chk(sfr_wr == (sfr_t && wrop), tag, {7'd0, sfr_wr}, {7'd0, sfr_t && wrop});
    if (sfr_t) begin
      chk(sfr_addr == tadr, tag, sfr_addr, tadr);
      chk(sfr_bitable == (tadr[2:0] == 3'd0), "R8", {7'd0, sfr_bitable}, {7'd0, tadr[2:0] == 3'd0});
      if (wrop && hit) chk(sfr_wdata == newv, tag, sfr_wdata, newv);
    end
    @(negedge clk);
    chk(rvalid == rdop, "R10", {7'd0, rvalid}, {7'd0, rdop});
    chk(err == (sfr_t && !hit), "R9", {7'd0, err}, {7'd0, sfr_t && !hit});
    if (rdop) begin
      expd = (sfr_t && !hit) ? 8'h00 : oldv;
      chk(rdata == expd, (sfr_t && !hit) ? "R9" : tag, rdata, expd);
      if (is_bit) chk(rbit == expd[bi], tag, {7'd0, rbit}, {7'd0, expd[bi]});
    end
    if (wrop) begin
      if (sfr_t) begin
        if (hit) sfr_mem[tadr[6:0]] = newv;
      end else begin
        ram[tadr] = newv;
      end
    end
    req_op = 4'd0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 128; i++) sfr_mem[i] = 8'($urandom);
    rst = 1'b1; req_op = 4'd0; req_addr = 8'd0; req_wdata = 8'd0; req_wbit = 1'b0; bank = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rvalid == 1'b0, "R1", {7'd0, rvalid}, 8'h00);
    chk(err == 1'b0, "R1", {7'd0, err}, 8'h00);
    chk(rdata == 8'h00, "R1", rdata, 8'h00);
    chk(rbit == 1'b0, "R1", {7'd0, rbit}, 8'h00);

    // Fill upper RAM through R0 of bank 0, then the lower half directly.
    for (int a = 128; a < 256; a++) begin
      do_op(4'd2, 8'h00, 8'(a), 1'b0);
      do_op(4'd4, 8'h00, 8'($urandom), 1'b0);
    end
    for (int a = 0; a < 128; a++) do_op(4'd2, 8'(a), 8'($urandom), 1'b0);

    // R2 bank-relative registers
    bank = 2'd2;
    do_op(4'd6, 8'h05, 8'h3C, 1'b0);
    do_op(4'd1, 8'h15, 8'h00, 1'b0);
    chk(rdata == 8'h3C, "R2", rdata, 8'h3C);
    bank = 2'd1;
    do_op(4'd5, 8'h05, 8'h00, 1'b0);

    // R3 indirect above 0x80 stays in RAM; R4 direct there goes to the port
    bank = 2'd3;
    do_op(4'd6, 8'h01, 8'h90, 1'b0);
    do_op(4'd4, 8'h01, 8'h5A, 1'b0);
    do_op(4'd2, 8'h90, 8'hC3, 1'b0);
    do_op(4'd3, 8'h01, 8'h00, 1'b0);
    chk(rdata == 8'h5A, "R3", rdata, 8'h5A);

    // R5 and R6 bit window corners
    do_op(4'd2, 8'h22, 8'h00, 1'b0);
    do_op(4'd8, 8'h13, 8'h00, 1'b0);
    do_op(4'd1, 8'h22, 8'h00, 1'b0);
    chk(rdata == 8'h08, "R5", rdata, 8'h08);
    do_op(4'd2, 8'h2F, 8'h7E, 1'b0);
    do_op(4'd8, 8'h7F, 8'h00, 1'b0);
    do_op(4'd1, 8'h2F, 8'h00, 1'b0);
    chk(rdata == 8'hFE, "R6", rdata, 8'hFE);
    do_op(4'd9, 8'h79, 8'h00, 1'b0);
    do_op(4'd10, 8'h78, 8'h00, 1'b1);
    do_op(4'd1, 8'h2F, 8'h00, 1'b0);
    chk(rdata == 8'hFD, "R6", rdata, 8'hFD);

    // R7, R8, R9 special-function corners
    do_op(4'd1, 8'h88, 8'h00, 1'b0);
    do_op(4'd1, 8'h89, 8'h00, 1'b0);
    do_op(4'd1, 8'h8F, 8'h00, 1'b0);
    do_op(4'd2, 8'hFF, 8'h11, 1'b0);
    do_op(4'd9, 8'hE7, 8'h00, 1'b0);
    do_op(4'd10, 8'h80, 8'h00, 1'b1);
    do_op(4'd7, 8'hE7, 8'h00, 1'b0);

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      bank = 2'($urandom);
      do_op(4'($urandom_range(0, 10)), 8'($urandom), 8'($urandom), 1'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule